// File: doc/BRIEF.md
# GPIO Pin Interrupt Detector

This block watches a bank of already-synchronized GPIO inputs and raises one shared interrupt line whenever any enabled pin meets its trigger condition. For each pin, software picks one of five triggers: rising edge, falling edge, either edge, high level or low level. Three configuration bits per pin select the trigger. A fourth bit gates the pin onto the shared line. A fifth bit acknowledges a latched edge.

Every per-pin bank is packed 32 pins to a 32-bit word. Software reaches the banks through a flat word-addressed register port. Writes take effect on the next clock. Read data is registered, so it appears one cycle after the address is presented. An interrupt handler reads the masked-status words to find which pins fired. For an edge pin, it then acknowledges by writing the pin's clear bit to 0 and then back to 1.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset, `irq` is 0, the trigger-kind, both-edge, polarity and enable banks read all zeros, the clear-control bank reads all ones, and no edge is latched.
- R2: Pin p sits in word p/32 at bit p%32 of every bank. The register address is bank*2^WIDX_W + word. The bank codes are: 0 trigger kind (1 edge, 0 level), 1 both-edge, 2 polarity, 3 enable, 4 clear control, 5 raw input (read only), 6 status (read only), 7 masked status (read only). `reg_rdata` presents the addressed word one cycle after the address. Bank 5 returns the current `pin_in` value.
- R3: With kind=1, both=0 and polarity=1, a pin latches status when its input is 1 and its previous sample was 0. The status stays set after the input returns low, until it is acknowledged.
- R4: With kind=1, both=0 and polarity=0, a pin latches status on a 1-to-0 change of its input.
- R5: With kind=1 and both=1, a pin latches status on either input change, whatever its polarity bit holds.
- R6: With kind=0, a pin's status equals its input when polarity=1 and the inverted input when polarity=0. The status is not latched, and the both-edge bit has no effect.
- R7: While a pin's clear bit is 0, its edge status is held at 0 and edges are not recorded. Writing 0 and then 1 acknowledges the pin. Detection resumes once the bit is back at 1.
- R8: Masked status is status AND enable. A pin whose enable bit is 0 cannot raise `irq`, but its status still shows in bank 6.
- R9: `irq` is a register holding the OR of masked status across all pins, from any word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | NUM_PINS | Synchronized pin levels |
| reg_wr | input | 1 | Write strobe for the addressed word |
| reg_addr | input | ADDR_W | Bank and word select |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| irq | output | 1 | Aggregated interrupt |

## Verification
Directed runs move one pin through rising, falling, both-edge and both level modes. These runs separate a latched edge from a followed level. They also show whether the polarity and both-edge bits are honoured or ignored. An edge delivered while the clear bit is 0 must leave nothing latched, and a pin held high across the acknowledge must not re-fire. These two cases separate a true hold-clear from a one-shot reset. Random phases draw per-pin configuration and sparse input flips, then compare every masked-status word and `irq` against a bench model. This catches wrong word or bit placement and missed cross-word OR terms.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int BUS_W = 32;

  typedef enum logic [2:0] {
    BK_KIND  = 3'd0,
    BK_BOTH  = 3'd1,
    BK_POL   = 3'd2,
    BK_EN    = 3'd3,
    BK_CLR   = 3'd4,
    BK_RAW   = 3'd5,
    BK_STAT  = 3'd6,
    BK_MSTAT = 3'd7
  } bank_e;

  // edge qualification for one pin
  function automatic logic edge_hit(input logic both, input logic pol,
                                    input logic cur, input logic prev);
    if (both) return cur ^ prev;
    if (pol)  return cur & ~prev;
    return ~cur & prev;
  endfunction
endpackage

// File: rtl/gpio_irq_cfg.sv
module gpio_irq_cfg
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 64,
  parameter int WIDX_W   = 1,
  parameter int ADDR_W   = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [BUS_W-1:0]    wr_data,
  output logic [NUM_PINS-1:0] kind,
  output logic [NUM_PINS-1:0] both,
  output logic [NUM_PINS-1:0] pol,
  output logic [NUM_PINS-1:0] en,
  output logic [NUM_PINS-1:0] clr
);
  localparam int NWORDS = NUM_PINS / BUS_W;

  bank_e             bank;
  logic [WIDX_W-1:0] widx;
  assign bank = bank_e'(wr_addr[ADDR_W-1 -: 3]);
  assign widx = wr_addr[WIDX_W-1:0];

  for (genvar w = 0; w < NWORDS; w++) begin : g_word
    logic [BUS_W-1:0] kind_r, both_r, pol_r, en_r, clr_r;
    logic             hit;
    assign hit = wr_en && (int'(widx) == w);

    always_ff @(posedge clk) begin
      if (rst) begin
        kind_r <= '0;
        both_r <= '0;
        pol_r  <= '0;
        en_r   <= '0;
        clr_r  <= '1;
      end else if (hit) begin
        case (bank)
          BK_KIND: kind_r <= wr_data;
          BK_BOTH: both_r <= wr_data;
          BK_POL:  pol_r  <= wr_data;
          BK_EN:   en_r   <= wr_data;
          BK_CLR:  clr_r  <= wr_data;
          default: ;
        endcase
      end
    end

    assign kind[w*BUS_W +: BUS_W] = kind_r;
    assign both[w*BUS_W +: BUS_W] = both_r;
    assign pol [w*BUS_W +: BUS_W] = pol_r;
    assign en  [w*BUS_W +: BUS_W] = en_r;
    assign clr [w*BUS_W +: BUS_W] = clr_r;
  end
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 64
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] pin_in,
  input  logic [NUM_PINS-1:0] kind,
  input  logic [NUM_PINS-1:0] both,
  input  logic [NUM_PINS-1:0] pol,
  input  logic [NUM_PINS-1:0] clr,
  output logic [NUM_PINS-1:0] edge_lat,
  output logic [NUM_PINS-1:0] status
);
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic prev_q, edge_q, lvl_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        prev_q <= pin_in[p];
        edge_q <= 1'b0;
        lvl_q  <= 1'b0;
      end else begin
        prev_q <= pin_in[p];
        lvl_q  <= ~(pin_in[p] ^ pol[p]);
        if (!clr[p]) edge_q <= 1'b0;
        else         edge_q <= edge_q | edge_hit(both[p], pol[p], pin_in[p], prev_q);
      end
    end

    assign edge_lat[p] = edge_q;
    assign status[p]   = kind[p] ? edge_q : lvl_q;
  end
endmodule

// File: rtl/gpio_irq_rdmux.sv
module gpio_irq_rdmux
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 64,
  parameter int WIDX_W   = 1,
  parameter int ADDR_W   = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   rd_addr,
  input  logic [NUM_PINS-1:0] kind,
  input  logic [NUM_PINS-1:0] both,
  input  logic [NUM_PINS-1:0] pol,
  input  logic [NUM_PINS-1:0] en,
  input  logic [NUM_PINS-1:0] clr,
  input  logic [NUM_PINS-1:0] raw,
  input  logic [NUM_PINS-1:0] status,
  output logic [BUS_W-1:0]    rdata
);
  localparam int NWORDS = NUM_PINS / BUS_W;

  bank_e             bank;
  logic [WIDX_W-1:0] widx;
  int                base;
  assign bank = bank_e'(rd_addr[ADDR_W-1 -: 3]);
  assign widx = rd_addr[WIDX_W-1:0];
  assign base = int'(widx) * BUS_W;

  always_ff @(posedge clk) begin
    if (rst || int'(widx) >= NWORDS) begin
      rdata <= '0;
    end else begin
      case (bank)
        BK_KIND:  rdata <= kind[base +: BUS_W];
        BK_BOTH:  rdata <= both[base +: BUS_W];
        BK_POL:   rdata <= pol[base +: BUS_W];
        BK_EN:    rdata <= en[base +: BUS_W];
        BK_CLR:   rdata <= clr[base +: BUS_W];
        BK_RAW:   rdata <= raw[base +: BUS_W];
        BK_STAT:  rdata <= status[base +: BUS_W];
        default:  rdata <= status[base +: BUS_W] & en[base +: BUS_W];
      endcase
    end
  end
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter  int NUM_PINS = 64,
  localparam int NWORDS   = NUM_PINS / BUS_W,
  localparam int WIDX_W   = (NWORDS > 1) ? $clog2(NWORDS) : 1,
  localparam int ADDR_W   = 3 + WIDX_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] pin_in,
  input  logic                reg_wr,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [BUS_W-1:0]    reg_wdata,
  output logic [BUS_W-1:0]    reg_rdata,
  output logic                irq
);
  logic [NUM_PINS-1:0] kind_w, both_w, pol_w, en_w, clr_w;
  logic [NUM_PINS-1:0] edge_w, stat_w;

  gpio_irq_cfg #(.NUM_PINS(NUM_PINS), .WIDX_W(WIDX_W), .ADDR_W(ADDR_W)) cfg_i (
    .clk(clk), .rst(rst), .wr_en(reg_wr), .wr_addr(reg_addr), .wr_data(reg_wdata),
    .kind(kind_w), .both(both_w), .pol(pol_w), .en(en_w), .clr(clr_w)
  );

  gpio_irq_detect #(.NUM_PINS(NUM_PINS)) det_i (
    .clk(clk), .rst(rst), .pin_in(pin_in), .kind(kind_w), .both(both_w),
    .pol(pol_w), .clr(clr_w), .edge_lat(edge_w), .status(stat_w)
  );

  gpio_irq_rdmux #(.NUM_PINS(NUM_PINS), .WIDX_W(WIDX_W), .ADDR_W(ADDR_W)) rd_i (
    .clk(clk), .rst(rst), .rd_addr(reg_addr), .kind(kind_w), .both(both_w),
    .pol(pol_w), .en(en_w), .clr(clr_w), .raw(pin_in), .status(stat_w),
    .rdata(reg_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |(stat_w & en_w);
  end
endmodule

// File: rtl/gpio_irq_chk.sv
module gpio_irq_chk #(
  parameter int NUM_PINS = 64
) (
  input logic                clk,
  input logic                rst,
  input logic [NUM_PINS-1:0] pin_in,
  input logic [NUM_PINS-1:0] kind,
  input logic [NUM_PINS-1:0] pol,
  input logic [NUM_PINS-1:0] en,
  input logic [NUM_PINS-1:0] clr,
  input logic [NUM_PINS-1:0] edge_lat,
  input logic [NUM_PINS-1:0] status,
  input logic                irq
);
  // R7: a zero clear bit leaves the edge latch empty one cycle later
  a_r7_hold_clear: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((edge_lat & ~$past(clr)) == '0));

  // R3: a latched edge survives while its clear bit stays 1
  a_r3_sticky: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((~edge_lat & $past(edge_lat & clr)) == '0));

  // R6: level pins mirror the polarity-qualified input of the prior cycle
  a_r6_level_follow: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((~kind & ~$past(kind) & (status ^ $past(pin_in ~^ pol))) == '0));

  // R9: the output line is the registered OR of masked status
  a_r9_irq_or: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq == $past(|(status & en))));
endmodule

bind gpio_irq_ctrl gpio_irq_chk #(.NUM_PINS(NUM_PINS)) chk_i (
  .clk(clk), .rst(rst), .pin_in(pin_in), .kind(kind_w), .pol(pol_w),
  .en(en_w), .clr(clr_w), .edge_lat(edge_w), .status(stat_w), .irq(irq)
);

// File: tb/gpio_irq_ctrl_tb_top.sv
module gpio_irq_ctrl_tb_top;
  localparam int NP = 64;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NP-1:0] pins = '0;
  logic          wr = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic          irq;

  int total = 0;
  int bad = 0;

  // bench model
  logic [NP-1:0] kind_m = '0, both_m = '0, pol_m = '0, en_m = '0;
  logic [NP-1:0] s_m = '0, p_m = '0;

  gpio_irq_ctrl #(.NUM_PINS(NP)) dut_i (
    .clk(clk), .rst(rst), .pin_in(pins), .reg_wr(wr), .reg_addr(addr),
    .reg_wdata(wdata), .reg_rdata(rdata), .irq(irq)
  );

  always #4 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wreg(input int bank, input int w, input logic [31:0] d);
    @(negedge clk);
    wr = 1'b1; addr = AW'((bank << 1) | w); wdata = d;
    case (bank)
      0: kind_m[w*32 +: 32] = d;
      1: both_m[w*32 +: 32] = d;
      2: pol_m[w*32 +: 32]  = d;
      3: en_m[w*32 +: 32]   = d;
      default: ;
    endcase
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rreg(input int bank, input int w, output logic [31:0] d);
    @(negedge clk);
    addr = AW'((bank << 1) | w);
    @(negedge clk);
    d = rdata;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  function automatic logic [NP-1:0] hits_of(input logic [NP-1:0] prev, input logic [NP-1:0] cur);
    logic [NP-1:0] h;
    for (int i = 0; i < NP; i++) begin
      if (both_m[i])     h[i] = prev[i] != cur[i];
      else if (pol_m[i]) h[i] = !prev[i] && cur[i];
      else               h[i] = prev[i] && !cur[i];
    end
    return h;
  endfunction

  function automatic logic [NP-1:0] stat_of(input logic [NP-1:0] cur);
    logic [NP-1:0] s;
    for (int i = 0; i < NP; i++)
      s[i] = kind_m[i] ? s_m[i] : (pol_m[i] ? cur[i] : !cur[i]);
    return s;
  endfunction

  task automatic drive(input logic [NP-1:0] n);
    @(negedge clk);
    pins = n;
    s_m = s_m | hits_of(p_m, n);
    p_m = n;
    settle();
  endtask

  task automatic ack_word(input int w, input logic [31:0] bits);
    wreg(4, w, ~bits);
    wreg(4, w, 32'hFFFF_FFFF);
    s_m[w*32 +: 32] = s_m[w*32 +: 32] & ~bits;
    settle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [NP-1:0] ms;
    void'($urandom(32'h5EED_1234));
    repeat (5) @(negedge clk);
    rst = 1'b0;
    settle();

    // R1 reset values
    check("R1 irq", {31'd0, irq}, 32'd0);
    rreg(4, 0, d); check("R1 clear bank", d, 32'hFFFF_FFFF);
    rreg(3, 1, d); check("R1 enable bank", d, 32'd0);
    rreg(0, 0, d); check("R1 kind bank", d, 32'd0);
    rreg(7, 0, d); check("R1 masked status", d, 32'd0);

    // R2 mapping: pin 40 -> word 1 bit 8
    wreg(0, 1, 32'h100); wreg(2, 1, 32'h100); wreg(3, 1, 32'h100);
    rreg(0, 1, d); check("R2 kind word1", d, 32'h100);
    rreg(0, 0, d); check("R2 kind word0 untouched", d, 32'd0);
    pins[35] = 1'b1; p_m = pins; settle();
    rreg(5, 1, d); check("R2 raw word1", d, 32'h8);
    rreg(5, 0, d); check("R2 raw word0", d, 32'd0);
    check("R8 unenabled pin no irq", {31'd0, irq}, 32'd0);

    // R3 rising edge, sticky
    drive(pins | (64'd1 << 40));
    rreg(7, 1, d); check("R3 rising latched", d, 32'h100);
    check("R3 irq", {31'd0, irq}, 32'd1);
    drive(pins & ~(64'd1 << 40));
    rreg(7, 1, d); check("R3 sticky after fall", d, 32'h100);

    // R7 acknowledge; edge during clear=0 ignored
    wreg(4, 1, ~32'h100);
    drive(pins | (64'd1 << 40));
    rreg(7, 1, d); check("R7 held clear", d, 32'd0);
    wreg(4, 1, 32'hFFFF_FFFF); settle();
    rreg(7, 1, d); check("R7 no refire after ack", d, 32'd0);
    check("R7 irq low", {31'd0, irq}, 32'd0);
    s_m = '0;

    // R4 falling edge
    wreg(2, 1, 32'h0);
    drive(pins & ~(64'd1 << 40));
    rreg(7, 1, d); check("R4 falling latched", d, 32'h100);
    ack_word(1, 32'h100);
    rreg(7, 1, d); check("R7 ack clears", d, 32'd0);

    // R5 both edges, polarity ignored
    wreg(1, 1, 32'h100);
    drive(pins | (64'd1 << 40));
    rreg(7, 1, d); check("R5 rise with pol=0", d, 32'h100);
    ack_word(1, 32'h100);
    drive(pins & ~(64'd1 << 40));
    rreg(7, 1, d); check("R5 fall", d, 32'h100);
    ack_word(1, 32'h100);

    // R6 level, both ignored, not latched
    wreg(0, 1, 32'h0); wreg(2, 1, 32'h100); settle();
    rreg(7, 1, d); check("R6 high level inactive", d, 32'd0);
    drive(pins | (64'd1 << 40));
    rreg(7, 1, d); check("R6 high level active", d, 32'h100);
    check("R6 irq", {31'd0, irq}, 32'd1);
    drive(pins & ~(64'd1 << 40));
    rreg(7, 1, d); check("R6 not latched", d, 32'd0);
    check("R6 irq drops", {31'd0, irq}, 32'd0);
    wreg(2, 1, 32'h0); settle();
    rreg(7, 1, d); check("R6 low level active", d, 32'h100);

    // R8 enable masking
    wreg(3, 1, 32'h0); settle();
    rreg(7, 1, d); check("R8 masked off", d, 32'd0);
    check("R8 irq masked", {31'd0, irq}, 32'd0);
    rreg(6, 1, d); check("R8 raw status word1", d, 32'hFFFF_FFF7);

    // R9 OR across words
    wreg(3, 0, 32'h1); settle();
    check("R9 word0 pin raises irq", {31'd0, irq}, 32'd1);
    drive(pins | 64'd1);
    check("R9 irq off", {31'd0, irq}, 32'd0);
    wreg(3, 1, 32'h100); settle();
    check("R9 word1 pin raises irq", {31'd0, irq}, 32'd1);

    // random phases
    for (int it = 0; it < 30; it++) begin
      for (int w = 0; w < 2; w++) begin
        wreg(0, w, $urandom); wreg(1, w, $urandom);
        wreg(2, w, $urandom); wreg(3, w, $urandom & $urandom);
      end
      wreg(4, 0, 32'h0); wreg(4, 1, 32'h0);
      wreg(4, 0, 32'hFFFF_FFFF); wreg(4, 1, 32'hFFFF_FFFF);
      s_m = '0; p_m = pins; settle();
      for (int st = 0; st < 6; st++) begin
        drive(pins ^ ({$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom}));
        ms = stat_of(pins) & en_m;
        for (int w = 0; w < 2; w++) begin
          rreg(7, w, d); check("R3/R4/R5/R6/R8 random masked", d, ms[w*32 +: 32]);
        end
        check("R9 random irq", {31'd0, irq}, {31'd0, |ms});
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule